// File: doc/BRIEF.md
# SoC System Control Register Bank

This block is the word-addressed control and status register bank of a small SoC. A bus master reaches it over a plain strobe, write-enable, address and data interface. Every access is a full 32-bit word. The word index comes from the byte address with the two lowest bits dropped. The bank holds GPIO registers, a debug scratch word, a sticky debug lock flag, a configuration-port command word and three constant identification words. It also decodes the register windows of the attached timer channels and muxes their read data onto the bus. The timers themselves live outside the block.

Some writes act on more than stored state. A configuration-port write whose low half-word carries the power-off command raises a one-cycle shutdown request. Any write to the identity word raises a one-cycle system-reset request. Any write to the lock word sets the lock flag, and only reset clears it. GPIO inputs pass through a two-stage synchronizer. When an enabled input bit changes, the block produces a one-cycle interrupt pulse.

Top module: `soc_ctrl_regs`

## Requirements
- R1: After reset the identity word (index 31) reads SYS_ID, the frequency word (index 29) reads CLK_HZ, the capability word (index 30) reads CAPS, the GPIO input word (index 0) reads STRAP with the pins held at STRAP, the configuration-port word (index 16) reads 1, and GPIO out, GPIO interrupt enable, scratch and lock all read 0.
- R2: The GPIO output word (index 1) and the GPIO interrupt-enable word (index 2) keep the low GPIO_W bits of a write. They read back zero-extended, and the output word drives gpio_out.
- R3: Writes to index 0, index 29, index 30 and any unmapped index change nothing. Reads of an unmapped index return 0.
- R4: A write to index 16 whose bits 15:0 equal 0x000E pulses shutdown_req high for exactly the one cycle after the write edge, whatever the upper bits hold. Any other value gives no pulse. The word keeps reading 1.
- R5: Any write to index 21 sets the lock flag, read in bit 0, even with data 0. Only reset clears the flag.
- R6: Any write to index 31 pulses reset_req high for the one cycle after the write edge and leaves the identity value unchanged.
- R7: The scratch word (index 20) stores and returns all 32 bits.
- R8: A change on an input bit whose enable bit is set gives gpio_irq high for one cycle, in the third cycle after the clock edge that first samples the change. A change on a disabled bit gives no pulse. The input word shows the synchronized level.
- R9: Timer channel n owns indices 4(n+1) to 4(n+1)+2. When the bus strobe is high and the index falls in that window, tmr_sel is one-hot on bit n and tmr_reg carries index bits 1:0. Reads in the window return tmr_rdata slice n. Index 4(n+1)+3 is unmapped, and with no strobe tmr_sel is 0.
- R10: Byte-address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| gpio_in | input | GPIO_W | Asynchronous GPIO inputs |
| gpio_out | output | GPIO_W | GPIO output register |
| gpio_irq | output | 1 | One-cycle GPIO change interrupt |
| tmr_sel | output | NUM_TIMERS | Per-channel timer window select |
| tmr_reg | output | 2 | Register index inside the timer window |
| tmr_rdata | input | 32*NUM_TIMERS | Timer read data, channel n in slice n |
| shutdown_req | output | 1 | One-cycle power-off request |
| reset_req | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with GPIO_W = 8, STRAP = 0x05, CLK_HZ = 50,000,000, CAPS = 0x3, two timer channels and the default SYS_ID. The narrow GPIO width lets wide writes show that the GPIO words truncate and zero-extend. The non-zero strap and capability values prove that the constant words come from the parameters. With two channels, the one-hot select and the read-data mux can be checked against both windows and against the unmapped gap that follows each window.

// File: rtl/soc_ctrl_pkg.sv
// Package: word indices, command codes and decoded strobe types shared by
// the system control register bank. Assumes a 5-bit word index space.
package soc_ctrl_pkg;

    localparam int W_GPIO_IN    = 0;
    localparam int W_GPIO_OUT   = 1;
    localparam int W_GPIO_IRQEN = 2;
    localparam int W_CFG        = 16;
    localparam int W_SCRATCH    = 20;
    localparam int W_LOCK       = 21;
    localparam int W_FREQ       = 29;
    localparam int W_CAPS       = 30;
    localparam int W_SYSID      = 31;

    localparam int TMR_BASE   = 4;
    localparam int TMR_STRIDE = 4;
    localparam int TMR_SPAN   = 3;

    localparam logic [15:0] CFG_CMD_POWEROFF = 16'h000E;
    localparam logic [31:0] CFG_READY_WORD   = 32'h0000_0001;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_GPIO_IN,
        RS_GPIO_OUT,
        RS_GPIO_IRQEN,
        RS_TIMER,
        RS_CFG,
        RS_SCRATCH,
        RS_LOCK,
        RS_FREQ,
        RS_CAPS,
        RS_SYSID
    } rd_src_e;

    typedef struct packed {
        logic gpio_out;
        logic gpio_irqen;
        logic cfg;
        logic scratch;
        logic lock;
        logic sysid;
    } wr_strobe_t;

endpackage

// File: rtl/soc_ctrl_decode.sv
// Address decoder: turns a word index plus strobe into write strobes, a
// read-source selector and per-channel timer window hits.
// Assumes NUM_TIMERS windows at 4(n+1) stay below index 16.
module soc_ctrl_decode
    import soc_ctrl_pkg::*;
#(
    parameter int WORD_W     = 5,
    parameter int NUM_TIMERS = 2
) (
    input  logic                  sel,
    input  logic                  we,
    input  logic [WORD_W-1:0]     word,
    output wr_strobe_t            wr,
    output rd_src_e               rsrc,
    output logic [NUM_TIMERS-1:0] tmr_hit
);

    logic wr_en;
    assign wr_en = sel && we;

    // Per-channel window match, one comparator pair per timer.
    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_tmr_win
        localparam int LO = TMR_BASE + n * TMR_STRIDE;
        localparam int HI = LO + TMR_SPAN;
        assign tmr_hit[n] = (word >= WORD_W'(LO)) && (word < WORD_W'(HI));
    end

    // Write strobes for the locally held registers.
    always_comb begin
        wr.gpio_out   = wr_en && (word == WORD_W'(W_GPIO_OUT));
        wr.gpio_irqen = wr_en && (word == WORD_W'(W_GPIO_IRQEN));
        wr.cfg        = wr_en && (word == WORD_W'(W_CFG));
        wr.scratch    = wr_en && (word == WORD_W'(W_SCRATCH));
        wr.lock       = wr_en && (word == WORD_W'(W_LOCK));
        wr.sysid      = wr_en && (word == WORD_W'(W_SYSID));
    end

    // Read source selection; unmatched indices fall to RS_NONE.
    always_comb begin
        if (|tmr_hit)                            rsrc = RS_TIMER;
        else if (word == WORD_W'(W_GPIO_IN))     rsrc = RS_GPIO_IN;
        else if (word == WORD_W'(W_GPIO_OUT))    rsrc = RS_GPIO_OUT;
        else if (word == WORD_W'(W_GPIO_IRQEN))  rsrc = RS_GPIO_IRQEN;
        else if (word == WORD_W'(W_CFG))         rsrc = RS_CFG;
        else if (word == WORD_W'(W_SCRATCH))     rsrc = RS_SCRATCH;
        else if (word == WORD_W'(W_LOCK))        rsrc = RS_LOCK;
        else if (word == WORD_W'(W_FREQ))        rsrc = RS_FREQ;
        else if (word == WORD_W'(W_CAPS))        rsrc = RS_CAPS;
        else if (word == WORD_W'(W_SYSID))       rsrc = RS_SYSID;
        else                                     rsrc = RS_NONE;
    end

endmodule

// File: rtl/soc_ctrl_gpio.sv
// GPIO slice: two-flop input synchronizer, output and interrupt-enable
// registers, and a one-cycle change interrupt for enabled bits.
// Assumes the pins rest at STRAP during reset.
module soc_ctrl_gpio #(
    parameter int               GPIO_W = 32,
    parameter logic [GPIO_W-1:0] STRAP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] pins,
    input  logic              wr_out,
    input  logic              wr_irqen,
    input  logic [GPIO_W-1:0] wdata,
    output logic [GPIO_W-1:0] in_sync,
    output logic [GPIO_W-1:0] out_q,
    output logic [GPIO_W-1:0] irqen_q,
    output logic              irq
);

    logic [GPIO_W-1:0] meta_q;
    logic [GPIO_W-1:0] prev_q;

    // Synchronize the pins and keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= STRAP;
            in_sync <= STRAP;
            prev_q  <= STRAP;
        end else begin
            meta_q  <= pins;
            in_sync <= meta_q;
            prev_q  <= in_sync;
        end
    end

    // Software-written output and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            irqen_q <= '0;
        end else begin
            if (wr_out)   out_q   <= wdata;
            if (wr_irqen) irqen_q <= wdata;
        end
    end

    // Registered interrupt pulse on any enabled level change.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |((in_sync ^ prev_q) & irqen_q);
    end

endmodule

// File: rtl/soc_ctrl_misc.sv
// Side-effect registers: power-off command detection, reset request on
// identity writes, debug scratch word and the sticky debug lock.
module soc_ctrl_misc
    import soc_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cfg,
    input  logic        wr_scratch,
    input  logic        wr_lock,
    input  logic        wr_sysid,
    input  logic [31:0] wdata,
    output logic        shutdown_req,
    output logic        reset_req,
    output logic [31:0] scratch_q,
    output logic        lock_q
);

    // One-cycle request pulses following the triggering write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown_req <= 1'b0;
            reset_req    <= 1'b0;
        end else begin
            shutdown_req <= wr_cfg && (wdata[15:0] == CFG_CMD_POWEROFF);
            reset_req    <= wr_sysid;
        end
    end

    // Scratch storage and the set-only lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            lock_q    <= 1'b0;
        end else begin
            if (wr_scratch) scratch_q <= wdata;
            if (wr_lock)    lock_q    <= 1'b1;
        end
    end

endmodule

// File: rtl/soc_ctrl_regs.sv
// Top: system control register bank. Word-only bus, combinational read data,
// timer windows decoded and muxed in. Assumes GPIO_W <= 32 and ADDR_W >= 7.
module soc_ctrl_regs
    import soc_ctrl_pkg::*;
#(
    parameter int               ADDR_W     = 7,
    parameter int               GPIO_W     = 32,
    parameter int               NUM_TIMERS = 2,
    parameter logic [GPIO_W-1:0] STRAP     = GPIO_W'(1),
    parameter logic [31:0]      CLK_HZ     = 32'd80_000_000,
    parameter logic [31:0]      CAPS       = 32'h0000_0000,
    parameter logic [31:0]      SYS_ID     = 32'h1001_4D31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [GPIO_W-1:0]        gpio_in,
    output logic [GPIO_W-1:0]        gpio_out,
    output logic                     gpio_irq,
    output logic [NUM_TIMERS-1:0]    tmr_sel,
    output logic [1:0]               tmr_reg,
    input  logic [NUM_TIMERS*32-1:0] tmr_rdata,
    output logic                     shutdown_req,
    output logic                     reset_req
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]     word;
    logic [1:0]            unused_byte_lane;
    wr_strobe_t            wr;
    rd_src_e               rsrc;
    logic [NUM_TIMERS-1:0] tmr_hit;
    logic [GPIO_W-1:0]     gpio_sync;
    logic [GPIO_W-1:0]     gpio_irqen;
    logic [31:0]           scratch_q;
    logic                  dbg_lock;
    logic [31:0]           tmr_rd;

    assign word             = bus_addr[ADDR_W-1:2];
    assign unused_byte_lane = bus_addr[1:0];
    assign tmr_sel          = bus_sel ? tmr_hit : '0;
    assign tmr_reg          = word[1:0];

    soc_ctrl_decode #(.WORD_W(WORD_W), .NUM_TIMERS(NUM_TIMERS)) u_dec (
        .sel     (bus_sel),
        .we      (bus_we),
        .word    (word),
        .wr      (wr),
        .rsrc    (rsrc),
        .tmr_hit (tmr_hit)
    );

    soc_ctrl_gpio #(.GPIO_W(GPIO_W), .STRAP(STRAP)) u_gpio (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (gpio_in),
        .wr_out   (wr.gpio_out),
        .wr_irqen (wr.gpio_irqen),
        .wdata    (bus_wdata[GPIO_W-1:0]),
        .in_sync  (gpio_sync),
        .out_q    (gpio_out),
        .irqen_q  (gpio_irqen),
        .irq      (gpio_irq)
    );

    soc_ctrl_misc u_misc (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_cfg       (wr.cfg),
        .wr_scratch   (wr.scratch),
        .wr_lock      (wr.lock),
        .wr_sysid     (wr.sysid),
        .wdata        (bus_wdata),
        .shutdown_req (shutdown_req),
        .reset_req    (reset_req),
        .scratch_q    (scratch_q),
        .lock_q       (dbg_lock)
    );

    // Pick the read data slice of the timer whose window matches.
    always_comb begin
        tmr_rd = '0;
        for (int n = 0; n < NUM_TIMERS; n++) begin
            if (tmr_hit[n]) tmr_rd = tmr_rdata[n*32 +: 32];
        end
    end

    // Read data mux over all sources.
    always_comb begin
        case (rsrc)
            RS_GPIO_IN:    bus_rdata = 32'(gpio_sync);
            RS_GPIO_OUT:   bus_rdata = 32'(gpio_out);
            RS_GPIO_IRQEN: bus_rdata = 32'(gpio_irqen);
            RS_TIMER:      bus_rdata = tmr_rd;
            RS_CFG:        bus_rdata = CFG_READY_WORD;
            RS_SCRATCH:    bus_rdata = scratch_q;
            RS_LOCK:       bus_rdata = {31'd0, dbg_lock};
            RS_FREQ:       bus_rdata = CLK_HZ;
            RS_CAPS:       bus_rdata = CAPS;
            RS_SYSID:      bus_rdata = SYS_ID;
            default:       bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/soc_ctrl_regs_chk.sv
// Checker for the register bank: request pulses, lock stickiness and
// timer window selection. Attached with bind below.
module soc_ctrl_regs_chk #(
    parameter int WORD_W     = 5,
    parameter int NUM_TIMERS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic [WORD_W-1:0]     bus_word,
    input logic [15:0]           bus_wlow,
    input logic                  shutdown_req,
    input logic                  reset_req,
    input logic [NUM_TIMERS-1:0] tmr_sel,
    input logic                  dbg_lock
);

    logic cmd_wr, id_wr, lock_wr;
    assign cmd_wr  = bus_sel && bus_we && (bus_word == WORD_W'(16)) && (bus_wlow == 16'h000E);
    assign id_wr   = bus_sel && bus_we && (bus_word == WORD_W'(31));
    assign lock_wr = bus_sel && bus_we && (bus_word == WORD_W'(21));

    assert_shutdown_follows_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> shutdown_req);
    assert_no_spurious_shutdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> !shutdown_req);
    assert_reset_follows_id_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        id_wr |=> reset_req);
    assert_no_spurious_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !id_wr |=> !reset_req);
    assert_lock_set_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |=> dbg_lock);
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_lock |=> dbg_lock);
    assert_tmr_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_sel));
    assert_tmr_sel_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (tmr_sel == '0));

endmodule

bind soc_ctrl_regs soc_ctrl_regs_chk #(.WORD_W(ADDR_W - 2), .NUM_TIMERS(NUM_TIMERS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_word     (bus_addr[ADDR_W-1:2]),
    .bus_wlow     (bus_wdata[15:0]),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .tmr_sel      (tmr_sel),
    .dbg_lock     (dbg_lock)
);

// File: tb/soc_ctrl_regs_test.sv
// Bench: table-driven register accesses, then directed side-effect,
// interrupt, timer window and reset tests.
module soc_ctrl_regs_test;

    localparam int          ADDR_W = 7;
    localparam int          GW     = 8;
    localparam int          NT     = 2;
    localparam logic [7:0]  STRAP  = 8'h05;
    localparam logic [31:0] HZ     = 32'd50_000_000;
    localparam logic [31:0] CAPSV  = 32'h0000_0003;
    localparam logic [31:0] IDV    = 32'h1001_4D31;
    localparam logic [31:0] T0D    = 32'hAAAA_0000;
    localparam logic [31:0] T1D    = 32'h5555_1111;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [GW-1:0]     gpio_in = STRAP;
    logic [GW-1:0]     gpio_out;
    logic              gpio_irq;
    logic [NT-1:0]     tmr_sel;
    logic [1:0]        tmr_reg;
    logic [NT*32-1:0]  tmr_rdata = {T1D, T0D};
    logic              shutdown_req;
    logic              reset_req;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    soc_ctrl_regs #(
        .ADDR_W(ADDR_W), .GPIO_W(GW), .NUM_TIMERS(NT), .STRAP(STRAP),
        .CLK_HZ(HZ), .CAPS(CAPSV), .SYS_ID(IDV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_irq(gpio_irq),
        .tmr_sel(tmr_sel), .tmr_reg(tmr_reg), .tmr_rdata(tmr_rdata),
        .shutdown_req(shutdown_req), .reset_req(reset_req)
    );

    typedef struct packed {
        logic        wr;
        logic [6:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'h04, 32'h1234_56A5, 32'h0, 8'd2},   // R2 write GPIO out
        '{1'b0, 7'h04, 32'h0,         32'hA5, 8'd2},  // R2 truncated readback
        '{1'b1, 7'h50, 32'hDEAD_BEEF, 32'h0, 8'd7},   // R7 scratch
        '{1'b0, 7'h50, 32'h0,         32'hDEAD_BEEF, 8'd7},
        '{1'b1, 7'h74, 32'h0,         32'h0, 8'd3},   // R3 frequency word
        '{1'b0, 7'h74, 32'h0,         HZ, 8'd3},
        '{1'b1, 7'h78, 32'hFFFF_FFFF, 32'h0, 8'd3},   // R3 capability word
        '{1'b0, 7'h78, 32'h0,         CAPSV, 8'd3},
        '{1'b1, 7'h00, 32'h0000_00FF, 32'h0, 8'd3},   // R3 GPIO input word
        '{1'b0, 7'h00, 32'h0,         32'h05, 8'd3},
        '{1'b1, 7'h0C, 32'h0000_1234, 32'h0, 8'd3},   // R3 unmapped index 3
        '{1'b0, 7'h0C, 32'h0,         32'h0, 8'd3},
        '{1'b0, 7'h5E, 32'h0,         32'h0, 8'd3},   // R3 unmapped index 23
        '{1'b1, 7'h09, 32'hFFFF_FF0F, 32'h0, 8'd10},  // R10 byte bits ignored
        '{1'b0, 7'h0A, 32'h0,         32'h0F, 8'd2},  // R2 enable readback
        '{1'b1, 7'h40, 32'h0,         32'h0, 8'd4},   // R4 non-command value
        '{1'b0, 7'h40, 32'h0,         32'h1, 8'd4},
        '{1'b1, 7'h53, 32'h0000_0042, 32'h0, 8'd10},  // R10 scratch via offset 3
        '{1'b0, 7'h51, 32'h0,         32'h42, 8'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called in the low phase; returns at the negedge after the write edge.
    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        do_reset();

        // R1 reset state
        bus_read(7'h7C, rd); check("R1 sysid", rd, IDV);
        bus_read(7'h74, rd); check("R1 freq", rd, HZ);
        bus_read(7'h78, rd); check("R1 caps", rd, CAPSV);
        bus_read(7'h00, rd); check("R1 gpio in", rd, 32'h05);
        bus_read(7'h40, rd); check("R1 cfg ready", rd, 32'h1);
        bus_read(7'h04, rd); check("R1 gpio out", rd, 32'h0);
        bus_read(7'h08, rd); check("R1 irq enable", rd, 32'h0);
        bus_read(7'h50, rd); check("R1 scratch", rd, 32'h0);
        bus_read(7'h54, rd); check("R1 lock", rd, 32'h0);
        check("R1 pulses idle", {30'd0, shutdown_req, reset_req}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end
        check("R2 gpio_out pins", 32'(gpio_out), 32'hA5);

        // R4 power-off command with junk upper bits
        bus_write(7'h40, 32'hFFFF_000E);
        check("R4 shutdown pulse", 32'(shutdown_req), 32'h1);
        @(negedge clk);
        check("R4 shutdown one cycle", 32'(shutdown_req), 32'h0);
        bus_write(7'h40, 32'h0000_000F);
        check("R4 other value no pulse", 32'(shutdown_req), 32'h0);
        bus_read(7'h40, rd); check("R4 cfg still ready", rd, 32'h1);

        // R6 identity write
        bus_write(7'h7C, 32'h0);
        check("R6 reset pulse", {31'd0, reset_req}, 32'h1);
        check("R6 no shutdown", {31'd0, shutdown_req}, 32'h0);
        @(negedge clk);
        check("R6 reset one cycle", {31'd0, reset_req}, 32'h0);
        bus_read(7'h7C, rd); check("R6 sysid unchanged", rd, IDV);

        // R5 lock with zero data, stays set, cleared by reset
        bus_write(7'h54, 32'h0);
        bus_read(7'h54, rd); check("R5 lock set by zero", rd, 32'h1);
        bus_write(7'h54, 32'h0);
        repeat (3) @(negedge clk);
        bus_read(7'h54, rd); check("R5 lock sticky", rd, 32'h1);
        do_reset();
        bus_read(7'h54, rd); check("R5 lock cleared by reset", rd, 32'h0);

        // R8 interrupt on enabled bit 0
        bus_write(7'h08, 32'h0000_000F);
        repeat (2) @(negedge clk);
        gpio_in = 8'h04;
        @(negedge clk); check("R8 irq idle c1", {31'd0, gpio_irq}, 32'h0);
        @(negedge clk); check("R8 irq idle c2", {31'd0, gpio_irq}, 32'h0);
        @(negedge clk); check("R8 irq pulse", {31'd0, gpio_irq}, 32'h1);
        @(negedge clk); check("R8 irq one cycle", {31'd0, gpio_irq}, 32'h0);
        bus_read(7'h00, rd); check("R8 synced input", rd, 32'h04);
        // R8 masked bit 7 gives nothing
        gpio_in = 8'h84;
        begin
            logic seen;
            seen = 1'b0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (gpio_irq) seen = 1'b1;
            end
            check("R8 masked no irq", {31'd0, seen}, 32'h0);
        end
        bus_read(7'h00, rd); check("R8 masked input visible", rd, 32'h84);

        // R9 timer windows
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 7'h14; #2;
        check("R9 t0 sel", 32'(tmr_sel), 32'h1);
        check("R9 t0 reg", 32'(tmr_reg), 32'h1);
        check("R9 t0 data", bus_rdata, T0D);
        bus_addr = 7'h28; #2;
        check("R9 t1 sel", 32'(tmr_sel), 32'h2);
        check("R9 t1 reg", 32'(tmr_reg), 32'h2);
        check("R9 t1 data", bus_rdata, T1D);
        bus_addr = 7'h1C; #2;
        check("R9 gap sel", 32'(tmr_sel), 32'h0);
        check("R9 gap data", bus_rdata, 32'h0);
        bus_addr = 7'h20; bus_sel = 1'b0; #2;
        check("R9 no strobe", 32'(tmr_sel), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule